// File: doc/BRIEF.md
# Processor Bus Ownership Controller

This block is the processor-side controller that decides when the processor may drive the external bus, and how it gives the bus up. It runs a single bus cycle at a time. Each cycle has an address phase of a fixed number of clocks, followed by a data phase of a fixed number of ready-qualified beats. The core holds a request level until it sees a completion pulse. The block raises a bus request output for as long as work is pending. It drives output enables for the address and data buses, and reports to the core when a cycle starts, completes or is aborted.

System logic takes the bus back through three inputs, each with its own effect:

- **Address hold** floats only the address bus. A data phase already under way keeps running.
- **Back-off** kills the running cycle at once. The cycle is later rerun from its first address clock.
- **Hold** waits for the running cycle to finish. After one turnaround clock it grants the bus and raises a hold acknowledge.

When these inputs are active together, back-off beats hold, and hold beats address hold.

Top module: `bus_own_ctrl`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it rises, the block is idle: all enables, pulses and `hold_ack` are low, and a request with no takeover input active starts a cycle at once.
- R2: `bus_req` is high in every clock where `cyc_req` is high or a cycle is in its address or data phase, including while the bus is held or backed off.
- R3: With no takeover input active, `cyc_start` pulses in the idle clock where `cyc_req` is high. The address phase then lasts ADDR_LEN clocks with `addr_oe` high. The data phase follows with `addr_oe` and `data_oe` high. `cyc_done` pulses in the clock of the BEATS-th `data_rdy`, and the block is idle in the next clock. At most one of start, done and abort is high in any clock.
- R4: An active `sys_addr_hold` drops `addr_oe` in the same clock. It freezes the address-phase clock count until it is released. In the data phase, `data_oe` stays high and beats keep counting to completion.
- R5: An active `sys_backoff` during a cycle raises `cyc_abort` and drops both enables in the same clock. The `data_rdy` in that clock is not counted. The block stays released while back-off remains high, and is idle in the clock after it falls.
- R6: A cycle aborted by back-off is rerun in full once back-off is gone and the request is still high: a new `cyc_start`, ADDR_LEN address clocks and BEATS fresh beats.
- R7: An active `sys_hold` lets the running cycle finish with both enables driven. The clock after completion (or after an idle clock with hold) is a turnaround clock with `hold_ack` low. `hold_ack` then rises and stays high while hold remains. It falls in the clock after the first clock in which hold is seen low.
- R8: Back-off overrides hold and address hold. Hold overrides address hold: with both hold and address hold active, `addr_oe` stays driven and the address phase keeps counting.
- R9: No cycle starts in a clock where any takeover input is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_req | input | 1 | Core request level, held until `cyc_done` |
| data_rdy | input | 1 | Ready for one data beat |
| sys_addr_hold | input | 1 | System request to float the address bus |
| sys_backoff | input | 1 | System request to abort and release at once |
| sys_hold | input | 1 | System request to take the bus after the cycle ends |
| bus_req | output | 1 | Processor wants the bus |
| addr_oe | output | 1 | Address bus output enable |
| data_oe | output | 1 | Data bus output enable |
| cyc_start | output | 1 | Pulse: cycle begins |
| cyc_done | output | 1 | Pulse: last beat accepted |
| cyc_abort | output | 1 | Pulse: cycle killed by back-off |
| hold_ack | output | 1 | Bus granted to system logic under hold |

## Verification
The bench builds the block with ADDR_LEN=2 and BEATS=3. Both values are small enough that every phase boundary can be reached within a few clocks: the clock where the address-hold stall ends, a back-off that lands after one beat, and the last-beat completion under hold. A three-beat burst also makes it visible whether an aborted cycle's beat count is cleared before the rerun.

// File: rtl/bus_own_pkg.sv
// Shared types for the bus ownership controller.
package bus_own_pkg;

    // Controller states; encoding is free, nothing outside decodes it.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDRESS,
        ST_DATA,
        ST_HOLD_WAIT,
        ST_HELD,
        ST_BACKED_OFF
    } bus_state_e;

endpackage

// File: rtl/takeover_prio.sv
// takeover_prio: resolves the three system takeover inputs into exclusive
// winners. Back-off beats hold, hold beats address hold.
// Assumes all inputs are synchronous to the bus clock.
module takeover_prio (
    input  logic sys_addr_hold,
    input  logic sys_backoff,
    input  logic sys_hold,
    output logic boff_win,
    output logic hold_win,
    output logic ahold_win,
    output logic any_win
);

    // Fixed-priority resolution of takeover requests.
    always_comb begin
        boff_win  = sys_backoff;
        hold_win  = sys_hold && !sys_backoff;
        ahold_win = sys_addr_hold && !sys_hold && !sys_backoff;
        any_win   = sys_backoff || sys_hold || sys_addr_hold;
    end

endmodule

// File: rtl/phase_counter.sv
// phase_counter: counts qualified events within one bus phase and flags the
// last one. Cleared whenever the owning phase is not active.
// Assumes clr and adv are never needed in the same clock.
module phase_counter #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic adv,
    output logic at_last
);

    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    // Event counter: clear outside the phase, step on each qualified event.
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else if (adv) cnt <= cnt + 1'b1;
    end

    // Last-event flag for the current count.
    always_comb at_last = (cnt == LAST);

endmodule

// File: rtl/bus_own_ctrl.sv
// bus_own_ctrl: processor-side bus ownership controller. Runs one bus cycle
// at a time (ADDR_LEN address clocks, then BEATS ready-qualified beats) and
// gives the bus up to system logic through address hold, back-off or hold.
// Assumes the core holds cyc_req until cyc_done and keeps it high after an
// abort when the cycle is to be rerun.
module bus_own_ctrl #(
    parameter int ADDR_LEN = 2,
    parameter int BEATS    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_req,
    input  logic data_rdy,
    input  logic sys_addr_hold,
    input  logic sys_backoff,
    input  logic sys_hold,
    output logic bus_req,
    output logic addr_oe,
    output logic data_oe,
    output logic cyc_start,
    output logic cyc_done,
    output logic cyc_abort,
    output logic hold_ack
);
    import bus_own_pkg::*;

    bus_state_e st, st_nxt;
    logic boff_w, hold_w, ahold_w, any_w;
    logic addr_last, beat_last;
    logic in_addr, in_data, in_cycle;

    takeover_prio u_prio (
        .sys_addr_hold (sys_addr_hold),
        .sys_backoff   (sys_backoff),
        .sys_hold      (sys_hold),
        .boff_win      (boff_w),
        .hold_win      (hold_w),
        .ahold_win     (ahold_w),
        .any_win       (any_w)
    );

    // Phase decode shared by counters and outputs.
    always_comb begin
        in_addr  = (st == ST_ADDRESS);
        in_data  = (st == ST_DATA);
        in_cycle = in_addr || in_data;
    end

    phase_counter #(.LIMIT(ADDR_LEN)) u_addr_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (!in_addr),
        .adv     (in_addr && !ahold_w),
        .at_last (addr_last)
    );

    phase_counter #(.LIMIT(BEATS)) u_beat_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (!in_data),
        .adv     (in_data && data_rdy && !boff_w),
        .at_last (beat_last)
    );

    // Next-state logic for bus ownership.
    always_comb begin
        st_nxt = st;
        case (st)
            ST_IDLE: begin
                if (boff_w)                  st_nxt = ST_BACKED_OFF;
                else if (hold_w)             st_nxt = ST_HOLD_WAIT;
                else if (!ahold_w && cyc_req) st_nxt = ST_ADDRESS;
            end
            ST_ADDRESS: begin
                if (boff_w)                     st_nxt = ST_BACKED_OFF;
                else if (addr_last && !ahold_w) st_nxt = ST_DATA;
            end
            ST_DATA: begin
                if (boff_w)                      st_nxt = ST_BACKED_OFF;
                else if (data_rdy && beat_last)  st_nxt = hold_w ? ST_HOLD_WAIT : ST_IDLE;
            end
            ST_HOLD_WAIT: begin
                if (boff_w)      st_nxt = ST_BACKED_OFF;
                else if (hold_w) st_nxt = ST_HELD;
                else             st_nxt = ST_IDLE;
            end
            ST_HELD: begin
                if (boff_w)        st_nxt = ST_BACKED_OFF;
                else if (!sys_hold) st_nxt = ST_IDLE;
            end
            ST_BACKED_OFF: begin
                if (!sys_backoff) st_nxt = ST_IDLE;
            end
            default: st_nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nxt;
    end

    // Bus enables, core pulses and grant output.
    always_comb begin
        bus_req   = cyc_req || in_cycle;
        addr_oe   = in_cycle && !boff_w && !ahold_w;
        data_oe   = in_data && !boff_w;
        cyc_start = (st == ST_IDLE) && cyc_req && !any_w;
        cyc_done  = in_data && data_rdy && beat_last && !boff_w;
        cyc_abort = in_cycle && boff_w;
        hold_ack  = (st == ST_HELD);
    end

endmodule

// File: rtl/bus_own_ctrl_chk.sv
// bus_own_ctrl_chk: temporal checks on the controller's ports, attached by
// bind. Assumes synchronous active-low reset.
module bus_own_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic cyc_req,
    input logic sys_addr_hold,
    input logic sys_backoff,
    input logic sys_hold,
    input logic bus_req,
    input logic addr_oe,
    input logic data_oe,
    input logic cyc_start,
    input logic cyc_done,
    input logic cyc_abort,
    input logic hold_ack
);

    a_r2_req_shown: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_req |-> bus_req);

    a_r3_one_event: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cyc_start, cyc_done, cyc_abort}));

    a_r4_addr_float: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_addr_hold && !sys_hold) |-> !addr_oe);

    a_r5_abort_release: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_abort |-> (!addr_oe && !data_oe && sys_backoff));

    a_r5_no_done_in_boff: assert property (@(posedge clk) disable iff (!rst_n)
        sys_backoff |-> !cyc_done);

    a_r7_ack_after_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_ack) |-> $past(sys_hold));

    a_r7_ack_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        hold_ack |-> (!addr_oe && !data_oe));

    a_r9_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_addr_hold || sys_backoff || sys_hold) |-> !cyc_start);

endmodule

bind bus_own_ctrl bus_own_ctrl_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cyc_req       (cyc_req),
    .sys_addr_hold (sys_addr_hold),
    .sys_backoff   (sys_backoff),
    .sys_hold      (sys_hold),
    .bus_req       (bus_req),
    .addr_oe       (addr_oe),
    .data_oe       (data_oe),
    .cyc_start     (cyc_start),
    .cyc_done      (cyc_done),
    .cyc_abort     (cyc_abort),
    .hold_ack      (hold_ack)
);

// File: tb/bus_own_ctrl_test.sv
// Bench for bus_own_ctrl: a vector table walked clock by clock, then
// directed reset and grant checks. Inputs change at the falling edge and
// outputs are sampled 1 ns later.
module bus_own_ctrl_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cyc_req = 1'b0, data_rdy = 1'b0;
    logic sys_addr_hold = 1'b0, sys_backoff = 1'b0, sys_hold = 1'b0;
    logic bus_req, addr_oe, data_oe, cyc_start, cyc_done, cyc_abort, hold_ack;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    bus_own_ctrl #(.ADDR_LEN(2), .BEATS(3)) uut (
        .clk (clk), .rst_n (rst_n), .cyc_req (cyc_req), .data_rdy (data_rdy),
        .sys_addr_hold (sys_addr_hold), .sys_backoff (sys_backoff),
        .sys_hold (sys_hold), .bus_req (bus_req), .addr_oe (addr_oe),
        .data_oe (data_oe), .cyc_start (cyc_start), .cyc_done (cyc_done),
        .cyc_abort (cyc_abort), .hold_ack (hold_ack)
    );

    logic [6:0] obs;
    always_comb obs = {bus_req, addr_oe, data_oe, cyc_start, cyc_done, cyc_abort, hold_ack};

    // Inputs {req, ahold, boff, hold, rdy} _ expected {breq, aoe, doe, start, done, abort, ack}
    localparam int NV = 55;
    localparam logic [11:0] VEC [NV] = '{
        // R3 plain cycle
        12'b00000_0000000, 12'b10000_1001000, 12'b10000_1100000, 12'b10000_1100000,
        12'b10001_1110000, 12'b10000_1110000, 12'b10001_1110000, 12'b10001_1110100,
        12'b00000_0000000,
        // R4 address hold stall, then during data; idx 17 is R9
        12'b10000_1001000, 12'b11000_1000000, 12'b11000_1000000, 12'b10000_1100000,
        12'b10000_1100000, 12'b11001_1010000, 12'b11001_1010000, 12'b11001_1010100,
        12'b11000_1000000, 12'b00000_0000000,
        // R6 back-off after one beat, full rerun
        12'b10000_1001000, 12'b10000_1100000, 12'b10000_1100000, 12'b10001_1110000,
        12'b10101_1000010, 12'b10100_1000000, 12'b10000_1000000, 12'b10000_1001000,
        12'b10000_1100000, 12'b10000_1100000, 12'b10001_1110000, 12'b10001_1110000,
        12'b10001_1110100,
        // R7 hold during a cycle
        12'b10000_1001000, 12'b10010_1100000, 12'b10010_1100000, 12'b10011_1110000,
        12'b10011_1110000, 12'b10011_1110100, 12'b10010_1000000, 12'b10010_1000001,
        12'b10000_1000001, 12'b00000_0000000,
        // R8 priority: hold over ahold, back-off over all
        12'b10000_1001000, 12'b11010_1100000, 12'b11010_1100000, 12'b11111_1000010,
        12'b00110_0000000, 12'b00010_0000000, 12'b00010_0000000, 12'b00010_0000000,
        12'b00000_0000001,
        // R5 back-off in the address phase
        12'b10000_1001000, 12'b00100_1000010, 12'b00000_0000000, 12'b00000_0000000
    };

    function automatic string tag_of(int i);
        if (i < 9)        return "R3";
        else if (i == 17) return "R9";
        else if (i < 19)  return "R4";
        else if (i < 32)  return "R6";
        else if (i < 42)  return "R7";
        else if (i < 51)  return "R8";
        else              return "R5";
    endfunction

    task automatic check(string req, string what, logic [6:0] act, logic [6:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic drive(logic r, logic ah, logic bo, logic ho, logic rd);
        cyc_req = r; sys_addr_hold = ah; sys_backoff = bo; sys_hold = ho; data_rdy = rd;
    endtask

    // Watchdog: a hung run ends as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        #1 check("R1", "in reset", obs, 7'b0000000);
        @(negedge clk);
        rst_n = 1'b1;
        #1 check("R1", "after release", obs, 7'b0000000);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VEC[i][11], VEC[i][10], VEC[i][9], VEC[i][8], VEC[i][7]);
            #1 check(tag_of(i), $sformatf("vector %0d", i), obs, VEC[i][6:0]);
        end

        // R2/R9: idle hold with a pending request, then grant
        @(negedge clk);
        drive(1, 0, 0, 1, 0);
        #1 check("R9", "hold blocks start", obs, 7'b1000000);
        @(negedge clk);
        #1 check("R7", "turnaround", obs, 7'b1000000);
        @(negedge clk);
        #1 check("R2", "request shown while held", obs, 7'b1000001);
        drive(1, 0, 0, 0, 0);
        @(negedge clk);
        #1 check("R7", "ack drops, start", obs, 7'b1001000);

        // R1: reset in the middle of a cycle
        @(negedge clk);
        rst_n = 1'b0;
        drive(0, 0, 0, 0, 0);
        @(negedge clk);
        #1 check("R1", "reset mid-cycle", obs, 7'b0000000);
        rst_n = 1'b1;
        @(negedge clk);
        drive(1, 0, 0, 0, 0);
        #1 check("R1", "idle after reset", obs, 7'b1001000);
        @(negedge clk);
        drive(0, 0, 0, 0, 0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule